// File: doc/BRIEF.md
# Dual-strobe programmable reference divider

This block divides one reference clock by a programmable ratio and hands a one-cycle comparison strobe to each of two phase-locked loops. Loop A is strobed where the divided waveform rises (count zero) and loop B where it falls (count equal to half the ratio), so the two loops never see their active events in the same cycle. A rate-select bit lets loop B skip every second falling event, running at half the comparison rate of loop A.

Ratio and rate-select are written together with a load pulse into a shadow register. The running counter picks up the shadow only when it wraps, or at once while both loops are idle. Dropping both loop enables parks the counter at zero, so re-enabling either loop restarts from a known phase.

Top module: `dual_ref_divider`

## Requirements
- R1: With ratio N (8 to 4095, 12-bit field), loop A strobes once every N input cycles, first in the cycle in which a loop enable rises from the all-idle state.
- R2: A loaded ratio of 0 to 7 is replaced by 8; `clamp_seen` reads 1 from the cycle after such a load and 0 from the cycle after a load of 8 or more; it resets to 0.
- R3: With `half_b_sel` loaded as 1, loop B strobes only on every second falling event, starting with the first one after restart; loaded as 0, it strobes on every falling event.
- R4: Loop A strobes at count 0 of the period and loop B at count floor(N/2), so the two strobes are never high in the same cycle.
- R5: A ratio loaded while running takes effect at the next period boundary; a load in the period's last cycle governs the very next period.
- R6: While both enables are low the count is held at zero and the shadowed ratio becomes active; counting restarts in phase when either enable rises.
- R7: Each strobe is held low while its own enable is low, without disturbing the other loop's timing.
- R8: Each strobe is one input cycle wide.
- R9: After reset both strobes are low, `clamp_seen` is 0 and the active ratio is 8 with loop B at full rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ratio_in | input | 12 | Ratio value to load |
| half_b_sel | input | 1 | Loaded with the ratio: 1 halves loop B's rate |
| ratio_load | input | 1 | One-cycle load of ratio_in and half_b_sel into the shadow |
| en_a | input | 1 | Loop A enable |
| en_b | input | 1 | Loop B enable |
| strobe_a | output | 1 | Loop A comparison strobe |
| strobe_b | output | 1 | Loop B comparison strobe |
| clamp_seen | output | 1 | Last load was clamped to the minimum ratio |

## Verification
The period wrap and a shadow load can land in the same cycle: the load pulse is driven exactly in the terminal-count cycle, and the bench expects the following period to already use the new ratio, with the strobe spacing measured across the boundary. A second case loads mid-period, where the old ratio must finish its period first; a third combines the coincident load with a clamped value. Every configuration also begins with a restart from idle, which the bench judges by expecting loop A's strobe in the very first enabled cycle.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

   typedef enum logic {
      B_FULL_RATE = 1'b0,
      B_HALF_RATE = 1'b1
   } b_rate_e;

   // Lower bound applied to any ratio before it reaches the counter.
   function automatic int unsigned floor_ratio(input int unsigned v, input int unsigned lo);
      return (v < lo) ? lo : v;
   endfunction

endpackage

// File: rtl/ratio_shadow.sv
module ratio_shadow #(
   parameter int RATIO_W   = 12,
   parameter int MIN_RATIO = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [RATIO_W-1:0] ratio_in,
   input  logic               sel_in,
   output logic [RATIO_W-1:0] next_ratio,
   output logic               next_sel,
   output logic               clamped
);
   localparam logic [RATIO_W-1:0] MIN_W = RATIO_W'(MIN_RATIO);

   logic [RATIO_W-1:0] shadow_q;
   logic               sel_q;
   logic               in_low;
   logic [RATIO_W-1:0] in_fixed;

   always_comb begin
      in_low   = (ratio_in < MIN_W);
      in_fixed = in_low ? MIN_W : ratio_in;
      // bypass lets a load in the wrap cycle reach the counter directly
      next_ratio = load ? in_fixed : shadow_q;
      next_sel   = load ? sel_in   : sel_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= MIN_W;
         sel_q    <= refdiv_pkg::B_FULL_RATE;
         clamped  <= 1'b0;
      end else if (load) begin
         shadow_q <= in_fixed;
         sel_q    <= sel_in;
         clamped  <= in_low;
      end
   end

   assert_shadow_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
      shadow_q >= MIN_W);
   assert_clamp_report_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (load && (ratio_in < MIN_W)) |=> clamped);
endmodule

// File: rtl/period_counter.sv
module period_counter #(
   parameter int RATIO_W   = 12,
   parameter int MIN_RATIO = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic [RATIO_W-1:0] next_ratio,
   input  logic               next_sel,
   output logic [RATIO_W-1:0] cnt,
   output logic [RATIO_W-1:0] active_ratio,
   output logic               active_sel
);
   localparam logic [RATIO_W-1:0] MIN_W = RATIO_W'(MIN_RATIO);
   localparam logic [RATIO_W-1:0] ONE_W = RATIO_W'(1);

   logic at_end;
   assign at_end = (cnt == active_ratio - ONE_W);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt          <= '0;
         active_ratio <= MIN_W;
         active_sel   <= refdiv_pkg::B_FULL_RATE;
      end else if (!run || at_end) begin
         cnt          <= '0;
         active_ratio <= next_ratio;
         active_sel   <= next_sel;
      end else begin
         cnt <= cnt + ONE_W;
      end
   end

   assert_cnt_in_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < active_ratio);
   assert_idle_parks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0));
   assert_ratio_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !at_end) |=> $stable(active_ratio));
endmodule

// File: rtl/strobe_gen.sv
module strobe_gen #(
   parameter int RATIO_W   = 12,
   parameter bit HALF_B_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               en_a,
   input  logic               en_b,
   input  logic [RATIO_W-1:0] cnt,
   input  logic [RATIO_W-1:0] active_ratio,
   input  logic               active_sel,
   output logic               strobe_a,
   output logic               strobe_b
);
   logic [RATIO_W-1:0] half_pt;
   logic               rise_evt;
   logic               fall_evt;
   logic               pass_b;

   always_comb begin
      half_pt  = active_ratio >> 1;
      rise_evt = run && (cnt == '0);
      fall_evt = run && (cnt == half_pt);
   end

   generate
      if (HALF_B_EN) begin : g_half_b
         logic skip_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         skip_q <= 1'b0;
            else if (!run)      skip_q <= 1'b0;
            else if (fall_evt)  skip_q <= ~skip_q;
         end
         assign pass_b = !(active_sel && skip_q);
      end else begin : g_full_b
         logic unused_sel;
         assign unused_sel = active_sel;
         assign pass_b     = 1'b1;
      end
   endgenerate

   assign strobe_a = en_a && rise_evt;
   assign strobe_b = en_b && fall_evt && pass_b;

   assert_edges_apart_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(strobe_a && strobe_b));
   assert_a_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_a |=> !strobe_a);
   assert_b_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_b |=> !strobe_b);
endmodule

// File: rtl/dual_ref_divider.sv
module dual_ref_divider #(
   parameter int RATIO_W   = 12,
   parameter int MIN_RATIO = 8,
   parameter bit HALF_B_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [RATIO_W-1:0] ratio_in,
   input  logic               half_b_sel,
   input  logic               ratio_load,
   input  logic               en_a,
   input  logic               en_b,
   output logic               strobe_a,
   output logic               strobe_b,
   output logic               clamp_seen
);
   generate
      if (RATIO_W < 4 || RATIO_W > 24) begin : g_bad_width
         $error("RATIO_W out of supported range");
      end
      if (MIN_RATIO < 2 || MIN_RATIO >= (1 << RATIO_W)) begin : g_bad_min
         $error("MIN_RATIO must be at least 2 and fit in RATIO_W");
      end
   endgenerate

   logic               run;
   logic [RATIO_W-1:0] next_ratio;
   logic               next_sel;
   logic [RATIO_W-1:0] cnt;
   logic [RATIO_W-1:0] active_ratio;
   logic               active_sel;

   assign run = en_a || en_b;

   ratio_shadow #(.RATIO_W(RATIO_W), .MIN_RATIO(MIN_RATIO)) u_shadow (
      .clk(clk), .rst_n(rst_n), .load(ratio_load), .ratio_in(ratio_in),
      .sel_in(half_b_sel), .next_ratio(next_ratio), .next_sel(next_sel),
      .clamped(clamp_seen));

   period_counter #(.RATIO_W(RATIO_W), .MIN_RATIO(MIN_RATIO)) u_count (
      .clk(clk), .rst_n(rst_n), .run(run), .next_ratio(next_ratio),
      .next_sel(next_sel), .cnt(cnt), .active_ratio(active_ratio),
      .active_sel(active_sel));

   strobe_gen #(.RATIO_W(RATIO_W), .HALF_B_EN(HALF_B_EN)) u_strobe (
      .clk(clk), .rst_n(rst_n), .run(run), .en_a(en_a), .en_b(en_b),
      .cnt(cnt), .active_ratio(active_ratio), .active_sel(active_sel),
      .strobe_a(strobe_a), .strobe_b(strobe_b));

   assert_restart_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!run ##1 en_a) |-> strobe_a);
endmodule

// File: tb/tb_dual_ref_divider.sv
module tb_dual_ref_divider;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] ratio_in = '0;
   logic        half_b_sel = 1'b0;
   logic        ratio_load = 1'b0;
   logic        en_a = 1'b0;
   logic        en_b = 1'b0;
   logic        strobe_a, strobe_b, clamp_seen;

   int checks = 0;
   int errors = 0;

   always #(CLK_P/2) clk = ~clk;

   dual_ref_divider dut (
      .clk(clk), .rst_n(rst_n), .ratio_in(ratio_in), .half_b_sel(half_b_sel),
      .ratio_load(ratio_load), .en_a(en_a), .en_b(en_b),
      .strobe_a(strobe_a), .strobe_b(strobe_b), .clamp_seen(clamp_seen));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
      end
   endtask

   function automatic int fix(input int r);
      return (r < 8) ? 8 : r;
   endfunction

   // Load r1/sr while idle, then enable and compare n cycles against an arithmetic model.
   task automatic run_seq(input int r1, input int sr, input int n, input int load_at,
                          input int r2, input bit ena, input bit enb);
      int mcnt, mr, pend, mtog;
      bit ea, eb;
      @(negedge clk);
      en_a = 0; en_b = 0;
      ratio_load = 1; ratio_in = 12'(r1); half_b_sel = sr[0];
      @(negedge clk);
      ratio_load = 0;
      #(CLK_P/2-1);
      chk(clamp_seen == (r1 < 8), "R2 clamp flag", clamp_seen, int'(r1 < 8));
      chk(!strobe_a && !strobe_b, "R7 idle strobes", {strobe_a, strobe_b}, 0);
      mcnt = 0; mr = fix(r1); pend = mr; mtog = 0;
      for (int t = 0; t < n; t++) begin
         @(negedge clk);
         en_a = ena; en_b = enb;
         ratio_load = (t == load_at);
         ratio_in = 12'(r2);
         #(CLK_P/2-1);
         ea = ena && (mcnt == 0);
         eb = enb && (mcnt == mr/2) && (sr == 0 || mtog == 0);
         // R1 R4 R6 R7: rising-edge strobe for A; R3 R4: falling-edge strobe for B
         chk(strobe_a == ea, "R1/R4 strobe_a", strobe_a, ea);
         chk(strobe_b == eb, (sr != 0) ? "R3 strobe_b" : "R4 strobe_b", strobe_b, eb);
         if (t == load_at) pend = fix(r2);
         if (mcnt == mr/2) mtog ^= 1;
         if (mcnt == mr - 1) begin mcnt = 0; mr = pend; end   // R5 boundary
         else mcnt++;
      end
      @(negedge clk);
      ratio_load = 0;
   endtask

   initial begin
      #(CLK_P*200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #(CLK_P/2-1);
      chk(!strobe_a && !strobe_b, "R9 reset strobes", {strobe_a, strobe_b}, 0);
      chk(clamp_seen == 0, "R9 reset flag", clamp_seen, 0);
      @(negedge clk);
      rst_n = 1;
      // R9: default ratio 8 at full rate, without any load
      begin
         for (int t = 0; t < 20; t++) begin
            @(negedge clk);
            en_a = 1; en_b = 1;
            #(CLK_P/2-1);
            chk(strobe_a == (t % 8 == 0), "R9 default a", strobe_a, int'(t % 8 == 0));
            chk(strobe_b == (t % 8 == 4), "R9 default b", strobe_b, int'(t % 8 == 4));
         end
      end
      // R1 R2 R3 R4 R6: sweep small ratios (including clamped ones) in both rate modes
      for (int r = 0; r <= 24; r++)
         for (int sr = 0; sr < 2; sr++)
            run_seq(r, sr, 4*fix(r) + 3, -1, 0, 1, 1);
      // R1: largest ratio, halved B
      run_seq(4095, 1, 2*4095 + 10, -1, 0, 1, 1);
      run_seq(4094, 0, 4094 + 10, -1, 0, 1, 1);
      // R7: one loop disabled
      run_seq(100, 1, 450, -1, 0, 1, 0);
      run_seq(100, 1, 450, -1, 0, 0, 1);
      run_seq(37, 0, 200, -1, 0, 0, 1);
      // R5: load coinciding with the wrap cycle, mid-period, and clamped at the wrap
      run_seq(10, 0, 80, 19, 13, 1, 1);
      run_seq(10, 0, 80, 23, 13, 1, 1);
      run_seq(9, 0, 60, 8, 3, 1, 1);
      run_seq(12, 1, 120, 35, 20, 1, 1);
      // R2: flag after a mid-run clamped load
      @(negedge clk);
      en_a = 1; ratio_load = 1; ratio_in = 12'd2;
      @(negedge clk);
      ratio_load = 0;
      #(CLK_P/2-1);
      chk(clamp_seen == 1, "R2 flag set", clamp_seen, 1);
      @(negedge clk);
      ratio_load = 1; ratio_in = 12'd8;
      @(negedge clk);
      ratio_load = 0;
      #(CLK_P/2-1);
      chk(clamp_seen == 0, "R2 flag clear", clamp_seen, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule